// File: doc/BRIEF.md
# IDE Host Configuration Timing Register File

This block holds the device-specific configuration registers of a disk host controller: two channel timing words, a device timing byte, an ultra-DMA control byte, an ultra-DMA timing word and a general configuration word. It answers configuration accesses that arrive with an 8-bit offset, a size code, write data and a write flag. The response is combinational, in the same cycle as the request. A write takes effect at the next rising clock edge.

Each register offset accepts only certain access sizes, and reads and writes have different legal sets. Any access in the device-specific region that falls outside those sets raises the error flag, returns zero and changes nothing. Offsets below 0x40 belong to the generic configuration header. The block passes them to a header port and returns that port's answer unchanged.

The block also watches writes to the standard command register at offset 0x04. From those writes it keeps an I/O-decode enable flag and a bus-master enable flag. It does not interpret the timing values. It only stores them and returns them.

Top module: `cfgt_regfile`

## Requirements
- R1: After reset, the primary and secondary timing words read 0x8000 (decode-enable bit 15 set), every other register reads 0, and both enable flags are 0.
- R2: A halfword access (size code 1) is legal at offsets 0x40 (primary timing), 0x42 (secondary timing), 0x4A (ultra-DMA timing) and 0x54 (configuration). A halfword write stores wdata[15:0], and a halfword read returns the full 16 bits in rdata[15:0].
- R3: A byte read (size code 0) at 0x41 returns bits 15:8 of the primary timing word, and at 0x43 returns bits 15:8 of the secondary timing word. Byte writes at these two offsets are illegal.
- R4: Byte reads and byte writes are legal at 0x44 (device timing) and 0x48 (ultra-DMA control). A write stores wdata[7:0].
- R5: A byte write at 0x54 replaces only bits 7:0 of the configuration word, and a byte write at 0x55 replaces only bits 15:8. A byte read at either offset returns that byte.
- R6: At offsets 0x40 and above, every other combination raises acc_error, returns rdata 0 and leaves all registers unchanged. This covers 32-bit accesses (size code 2), size code 3, unlisted offsets, and sizes not listed for an offset.
- R7: An access below offset 0x40 asserts hdr_req and forwards the write flag, offset, size and data. acc_rdata and acc_error then equal hdr_rdata and hdr_error.
- R8: A write of any size to offset 0x04 loads io_enable from wdata bit 0 and bm_enable from wdata bit 2. No other access changes either flag.
- R9: Every register read returns zeros above the width of the data read (bits 31:8 for byte reads, bits 31:16 for halfword reads). With acc_valid low, rdata and error are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| acc_valid | input | 1 | Access request this cycle |
| acc_write | input | 1 | 1 for write, 0 for read |
| acc_offset | input | 8 | Configuration byte offset |
| acc_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| acc_wdata | input | 32 | Write data, least significant byte aligned |
| acc_rdata | output | 32 | Read data, same cycle |
| acc_error | output | 1 | Illegal access flag, same cycle |
| hdr_req | output | 1 | Header port request |
| hdr_write | output | 1 | Header port write flag |
| hdr_offset | output | 6 | Header port offset |
| hdr_size | output | 2 | Header port size code |
| hdr_wdata | output | 32 | Header port write data |
| hdr_rdata | input | 32 | Header port read data |
| hdr_error | input | 1 | Header port error |
| io_enable | output | 1 | I/O decode enable flag |
| bm_enable | output | 1 | Bus-master enable flag |

## Verification
The assertions assume the header port answers in the same cycle as hdr_req. They also assume the access inputs are stable from one falling edge to the next, so each access is seen by exactly one rising edge. The stimulus drives every access at a falling edge and lowers acc_valid soon after the rising edge. The header responder is a pure function of the offset and raises its error only at offset 0x3C, so the expected header answer is always known.

// File: rtl/cfgt_pkg.sv
package cfgt_pkg;

    localparam int OFS_W  = 8;
    localparam int DATA_W = 32;
    localparam int REG_W  = 16;
    localparam int HDR_W  = 6;

    localparam logic [OFS_W-1:0] DEV_BASE  = 8'h40;
    localparam logic [OFS_W-1:0] CMD_OFS   = 8'h04;
    localparam logic [OFS_W-1:0] OFS_PRI   = 8'h40;
    localparam logic [OFS_W-1:0] OFS_SEC   = 8'h42;
    localparam logic [OFS_W-1:0] OFS_DEV   = 8'h44;
    localparam logic [OFS_W-1:0] OFS_UCTL  = 8'h48;
    localparam logic [OFS_W-1:0] OFS_UTIM  = 8'h4A;
    localparam logic [OFS_W-1:0] OFS_CFG   = 8'h54;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_BAD  = 2'd3
    } acc_size_e;

    typedef enum logic [2:0] {
        T_NONE, T_HDR, T_PRI, T_SEC, T_DEV, T_UCTL, T_UTIM, T_CFG
    } target_e;

    typedef struct packed {
        target_e tgt;
        logic    hi;
        logic    half;
        logic    err;
    } decode_t;

    typedef struct packed {
        logic [REG_W-1:0] pri;
        logic [REG_W-1:0] sec;
        logic [7:0]       dev;
        logic [7:0]       uctl;
        logic [REG_W-1:0] utim;
        logic [REG_W-1:0] cfg;
    } regs_t;

    function automatic logic [REG_W-1:0] zext_byte(input logic [7:0] b);
        return {{(REG_W-8){1'b0}}, b};
    endfunction

endpackage

// File: rtl/cfgt_decode.sv
module cfgt_decode
    import cfgt_pkg::*;
(
    input  logic             valid,
    input  logic             write,
    input  logic [OFS_W-1:0] offset,
    input  acc_size_e        size,
    output decode_t          dec
);
    always_comb begin
        dec      = '0;
        dec.tgt  = T_NONE;
        if (valid) begin
            if (offset < DEV_BASE) begin
                dec.tgt = T_HDR;
            end else begin
                unique case (size)
                    SZ_BYTE: begin
                        if (offset == OFS_DEV)                dec.tgt = T_DEV;
                        else if (offset == OFS_UCTL)          dec.tgt = T_UCTL;
                        else if (offset == OFS_CFG)           dec.tgt = T_CFG;
                        else if (offset == OFS_CFG + 8'd1) begin
                            dec.tgt = T_CFG;
                            dec.hi  = 1'b1;
                        end else if (!write && offset == OFS_PRI + 8'd1) begin
                            dec.tgt = T_PRI;
                            dec.hi  = 1'b1;
                        end else if (!write && offset == OFS_SEC + 8'd1) begin
                            dec.tgt = T_SEC;
                            dec.hi  = 1'b1;
                        end else begin
                            dec.err = 1'b1;
                        end
                    end
                    SZ_HALF: begin
                        dec.half = 1'b1;
                        if (offset == OFS_PRI)       dec.tgt = T_PRI;
                        else if (offset == OFS_SEC)  dec.tgt = T_SEC;
                        else if (offset == OFS_UTIM) dec.tgt = T_UTIM;
                        else if (offset == OFS_CFG)  dec.tgt = T_CFG;
                        else                         dec.err = 1'b1;
                    end
                    default: dec.err = 1'b1;
                endcase
            end
        end
    end
endmodule

// File: rtl/cfgt_store.sv
module cfgt_store
    import cfgt_pkg::*;
#(
    parameter logic [REG_W-1:0] TIM_RST = 16'h8000
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  decode_t          dec,
    input  logic [REG_W-1:0] wdata,
    output regs_t            regs,
    output logic [REG_W-1:0] rdata
);
    always_ff @(posedge clk) begin
        if (rst) begin
            regs      <= '0;
            regs.pri  <= TIM_RST;
            regs.sec  <= TIM_RST;
        end else if (we) begin
            unique case (dec.tgt)
                T_PRI:  regs.pri  <= wdata;
                T_SEC:  regs.sec  <= wdata;
                T_DEV:  regs.dev  <= wdata[7:0];
                T_UCTL: regs.uctl <= wdata[7:0];
                T_UTIM: regs.utim <= wdata;
                T_CFG: begin
                    if (dec.half)    regs.cfg       <= wdata;
                    else if (dec.hi) regs.cfg[15:8] <= wdata[7:0];
                    else             regs.cfg[7:0]  <= wdata[7:0];
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        unique case (dec.tgt)
            T_PRI:  rdata = dec.half ? regs.pri : zext_byte(regs.pri[15:8]);
            T_SEC:  rdata = dec.half ? regs.sec : zext_byte(regs.sec[15:8]);
            T_DEV:  rdata = zext_byte(regs.dev);
            T_UCTL: rdata = zext_byte(regs.uctl);
            T_UTIM: rdata = regs.utim;
            T_CFG:  rdata = dec.half ? regs.cfg :
                            dec.hi   ? zext_byte(regs.cfg[15:8]) : zext_byte(regs.cfg[7:0]);
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/cfgt_cmd_flags.sv
module cfgt_cmd_flags
    import cfgt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             valid,
    input  logic             write,
    input  logic [OFS_W-1:0] offset,
    input  logic             io_bit,
    input  logic             bm_bit,
    output logic             io_enable,
    output logic             bm_enable
);
    always_ff @(posedge clk) begin
        if (rst) begin
            io_enable <= 1'b0;
            bm_enable <= 1'b0;
        end else if (valid && write && offset == CMD_OFS) begin
            io_enable <= io_bit;
            bm_enable <= bm_bit;
        end
    end
endmodule

// File: rtl/cfgt_regfile.sv
module cfgt_regfile
    import cfgt_pkg::*;
#(
    parameter logic [REG_W-1:0] TIM_RST = 16'h8000
)(
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [OFS_W-1:0]  acc_offset,
    input  logic [1:0]        acc_size,
    input  logic [DATA_W-1:0] acc_wdata,
    output logic [DATA_W-1:0] acc_rdata,
    output logic              acc_error,
    output logic              hdr_req,
    output logic              hdr_write,
    output logic [HDR_W-1:0]  hdr_offset,
    output logic [1:0]        hdr_size,
    output logic [DATA_W-1:0] hdr_wdata,
    input  logic [DATA_W-1:0] hdr_rdata,
    input  logic              hdr_error,
    output logic              io_enable,
    output logic              bm_enable
);
    decode_t          dec;
    regs_t            regs;
    logic [REG_W-1:0] reg_rdata;
    logic             reg_we;

    cfgt_decode u_dec (
        .valid  (acc_valid),
        .write  (acc_write),
        .offset (acc_offset),
        .size   (acc_size_e'(acc_size)),
        .dec    (dec)
    );

    assign reg_we = acc_valid && acc_write && !dec.err &&
                    dec.tgt != T_HDR && dec.tgt != T_NONE;

    cfgt_store #(.TIM_RST(TIM_RST)) u_store (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .dec   (dec),
        .wdata (acc_wdata[REG_W-1:0]),
        .regs  (regs),
        .rdata (reg_rdata)
    );

    cfgt_cmd_flags u_flags (
        .clk       (clk),
        .rst       (rst),
        .valid     (acc_valid),
        .write     (acc_write),
        .offset    (acc_offset),
        .io_bit    (acc_wdata[0]),
        .bm_bit    (acc_wdata[2]),
        .io_enable (io_enable),
        .bm_enable (bm_enable)
    );

    assign hdr_req    = (dec.tgt == T_HDR);
    assign hdr_write  = acc_write;
    assign hdr_offset = acc_offset[HDR_W-1:0];
    assign hdr_size   = acc_size;
    assign hdr_wdata  = acc_wdata;

    always_comb begin
        if (hdr_req) begin
            acc_rdata = hdr_rdata;
            acc_error = hdr_error;
        end else begin
            acc_rdata = dec.err ? '0 : {{(DATA_W-REG_W){1'b0}}, reg_rdata};
            acc_error = dec.err;
        end
    end

    // R1
    reset_val_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (regs.pri == TIM_RST && regs.sec == TIM_RST && regs.cfg == '0
                        && !io_enable && !bm_enable));

    // R6
    err_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_error && !hdr_req) |=> $stable(regs));

    // R6
    err_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_error && !hdr_req) |-> (acc_rdata == '0));

    // R7
    region_no_hdr_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_offset >= DEV_BASE) |-> !hdr_req);

    // R8
    flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !(acc_valid && acc_write && acc_offset == CMD_OFS) |=>
            ($stable(io_enable) && $stable(bm_enable)));

    // R5
    cfg_lo_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_valid && acc_write && acc_size == 2'd0 && acc_offset == OFS_CFG + 8'd1)
            |=> $stable(regs.cfg[7:0]));

    // R9
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !acc_valid |-> (acc_rdata == '0 && !acc_error && !hdr_req));
endmodule

// File: tb/sim_cfgt_regfile.sv
module sim_cfgt_regfile;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic [7:0]  acc_offset = '0;
    logic [1:0]  acc_size = '0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] acc_rdata;
    logic        acc_error;
    logic        hdr_req, hdr_write;
    logic [5:0]  hdr_offset;
    logic [1:0]  hdr_size;
    logic [31:0] hdr_wdata;
    logic [31:0] hdr_rdata;
    logic        hdr_error;
    logic        io_enable, bm_enable;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // reference state
    int m_pri, m_sec, m_dev, m_uctl, m_utim, m_cfg;
    bit m_io, m_bm;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign hdr_rdata = {16'hC0DE, 2'b00, hdr_offset, 8'h5A};
    assign hdr_error = hdr_req && (hdr_offset == 6'h3C);

    cfgt_regfile u0 (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_offset(acc_offset), .acc_size(acc_size), .acc_wdata(acc_wdata),
        .acc_rdata(acc_rdata), .acc_error(acc_error), .hdr_req(hdr_req),
        .hdr_write(hdr_write), .hdr_offset(hdr_offset), .hdr_size(hdr_size),
        .hdr_wdata(hdr_wdata), .hdr_rdata(hdr_rdata), .hdr_error(hdr_error),
        .io_enable(io_enable), .bm_enable(bm_enable)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // enable flags compared against the model on every clock
    always @(negedge clk) begin
        if (!rst && !finished) begin
            check("R8 io_enable", {31'd0, io_enable}, {31'd0, m_io});
            check("R8 bm_enable", {31'd0, bm_enable}, {31'd0, m_bm});
        end
    end

    // model of the legal map: returns legality and read value
    task automatic model_eval(input bit wr, input int off, input int sz,
                              output bit legal, output int rv);
        legal = 0;
        rv = 0;
        if (sz == 1) begin
            legal = 1;
            case (off)
                'h40: rv = m_pri;
                'h42: rv = m_sec;
                'h4A: rv = m_utim;
                'h54: rv = m_cfg;
                default: legal = 0;
            endcase
        end else if (sz == 0) begin
            legal = 1;
            case (off)
                'h41: begin rv = m_pri >> 8; legal = !wr; end
                'h43: begin rv = m_sec >> 8; legal = !wr; end
                'h44: rv = m_dev;
                'h48: rv = m_uctl;
                'h54: rv = m_cfg & 'hFF;
                'h55: rv = m_cfg >> 8;
                default: legal = 0;
            endcase
        end
        if (!legal) rv = 0;
    endtask

    task automatic model_commit(input int off, input int sz, input int wd);
        if (sz == 1) begin
            case (off)
                'h40: m_pri  = wd & 'hFFFF;
                'h42: m_sec  = wd & 'hFFFF;
                'h4A: m_utim = wd & 'hFFFF;
                'h54: m_cfg  = wd & 'hFFFF;
                default: ;
            endcase
        end else begin
            case (off)
                'h44: m_dev  = wd & 'hFF;
                'h48: m_uctl = wd & 'hFF;
                'h54: m_cfg  = (m_cfg & 'hFF00) | (wd & 'hFF);
                'h55: m_cfg  = (m_cfg & 'h00FF) | ((wd & 'hFF) << 8);
                default: ;
            endcase
        end
    endtask

    task automatic acc(input bit wr, input int off, input int sz, input int wd, input string req);
        bit legal;
        int rv;
        logic [31:0] exp_r;
        bit exp_e;
        @(negedge clk);
        acc_valid  = 1'b1;
        acc_write  = wr;
        acc_offset = off[7:0];
        acc_size   = sz[1:0];
        acc_wdata  = wd;
        #1;
        if (off < 'h40) begin
            exp_r = {16'hC0DE, 2'b00, off[5:0], 8'h5A};
            exp_e = (off == 'h3C);
            check({req, " hdr_req"}, {31'd0, hdr_req}, 32'd1);
        end else begin
            model_eval(wr, off, sz, legal, rv);
            exp_r = rv;
            exp_e = !legal;
            check({req, " hdr_req"}, {31'd0, hdr_req}, 32'd0);
        end
        check({req, " error"}, {31'd0, acc_error}, {31'd0, exp_e});
        if (!wr || exp_e) check({req, " rdata"}, acc_rdata, exp_r);
        @(posedge clk);
        if (wr && off >= 'h40 && !exp_e) model_commit(off, sz, wd);
        if (wr && off == 'h04) begin
            m_io = wd[0];
            m_bm = wd[2];
        end
        #1;
        acc_valid = 1'b0;
    endtask

    task automatic read_all(input string req);
        acc(0, 'h40, 1, 0, req);
        acc(0, 'h42, 1, 0, req);
        acc(0, 'h44, 0, 0, req);
        acc(0, 'h48, 0, 0, req);
        acc(0, 'h4A, 1, 0, req);
        acc(0, 'h54, 1, 0, req);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        bad++;
        total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        m_pri = 'h8000; m_sec = 'h8000; m_dev = 0; m_uctl = 0; m_utim = 0; m_cfg = 0;
        m_io = 0; m_bm = 0;
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;

        // R1 reset values
        read_all("R1");
        @(negedge clk);
        #1;
        check("R9 idle rdata", acc_rdata, 32'd0);
        check("R9 idle error", {31'd0, acc_error}, 32'd0);

        // R2 halfword writes and reads
        acc(1, 'h40, 1, 'hFFFF_1234, "R2");
        acc(1, 'h42, 1, 'h0000_A5C3, "R2");
        acc(1, 'h4A, 1, 'h0000_0F0E, "R2");
        acc(1, 'h54, 1, 'h0000_BEEF, "R2");
        read_all("R2");

        // R3 upper timing bytes
        acc(0, 'h41, 0, 0, "R3");
        acc(0, 'h43, 0, 0, "R3");
        acc(1, 'h40, 1, 'h7E01, "R3");
        acc(0, 'h41, 0, 0, "R3");

        // R4 byte registers
        acc(1, 'h44, 0, 'hFFFF_FF9C, "R4");
        acc(1, 'h48, 0, 'h0000_0107, "R4");
        acc(0, 'h44, 0, 0, "R4");
        acc(0, 'h48, 0, 0, "R4");

        // R5 config byte lanes
        acc(1, 'h54, 0, 'h11, "R5");
        acc(0, 'h54, 1, 0, "R5");
        acc(1, 'h55, 0, 'h22, "R5");
        acc(0, 'h54, 1, 0, "R5");
        acc(0, 'h55, 0, 0, "R5");
        acc(0, 'h54, 0, 0, "R5");

        // R6 illegal accesses in the device region
        acc(1, 'h41, 0, 'hAA, "R6");
        acc(1, 'h43, 0, 'hAA, "R6");
        acc(0, 'h40, 2, 0, "R6");
        acc(1, 'h40, 2, 'h1111_1111, "R6");
        acc(1, 'h44, 1, 'h3333, "R6");
        acc(0, 'h46, 0, 0, "R6");
        acc(1, 'h4A, 0, 'h55, "R6");
        acc(1, 'h54, 3, 'h7777, "R6");
        acc(0, 'hFF, 0, 0, "R6");
        read_all("R6");
        acc(0, 'h41, 0, 0, "R6");

        // R7 header forwarding
        acc(0, 'h00, 1, 0, "R7");
        acc(0, 'h3C, 0, 0, "R7");
        acc(0, 'h3F, 2, 0, "R7");

        // R8 command register flags
        acc(1, 'h04, 1, 'h0005, "R8");
        acc(1, 'h06, 1, 'h0000, "R8");
        acc(1, 'h44, 0, 'h00, "R8");
        acc(1, 'h04, 0, 'h04, "R8");
        acc(1, 'h04, 2, 'h0000_0001, "R8");
        acc(0, 'h04, 1, 0, "R8");
        @(negedge clk);
        @(negedge clk);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule